// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block puts the command interface of a NOR-style parallel flash, using the widely known CFI command set, in front of a small byte array built from on-chip registers. A host reaches it over a simple synchronous bus. It sets an address, a write word, a read strobe, a write strobe and an access size of one, two or four bytes. The array powers up erased, so every byte reads 0xFF.

Writes are not plain stores. Each write is decoded as one step of a command sequence, and a cycle counter tracks how far the sequence has gone. The first step names the operation. Later steps supply the data, a confirm code, or a word count. While a sequence is open, the command most recently latched decides what a read returns: array bytes, the status register or a byte of the query table. All operations finish in the cycle that completes them, so the ready bit in status is set at once.

Top module: `flashCmdTop`

## Requirements
- R1: After reset the array reads as all 0xFF, status reads 0x80 and reads return array data.
- R2: Writing 0xFF as the first step, or at the confirm step of a block erase, returns the block to read-array mode and to the first step.
- R3: A first step of 0x10 or 0x40 arms a program. The next write stores its data at its address with its access size and sets status bit 7.
- R4: A first step of 0x20 followed by 0xD0 sets every byte of one sector to 0xFF and sets status bit 7. The same first step followed by 0xFF changes no array byte.
- R5: The erased sector is the one whose base is the write address with its low SECTOR_LOG2 bits cleared. Bytes of every other sector keep their values.
- R6: While the latched command is 0x20, 0x50, 0x60, 0x70 or 0xE8, a read returns the status register zero-extended. A first step of 0x50 clears the status register to 0x00.
- R7: A first step of 0x60 followed by 0xD0 or 0x01 completes without touching the array and leaves status readable. Any other second value returns to read-array mode.
- R8: After 0x98, a read returns the query byte indexed by the low 8 address bits. Indices 0x10, 0x11 and 0x12 give 0x51, 0x52 and 0x59, index 0x27 gives ADDR_W, and indices at or above 0x40 give 0x00.
- R9: 0xE8 sets status bit 7. The next write gives a count N in its low byte. The following N+1 writes store data words, and a final 0xD0 completes the sequence with status bit 7 set.
- R10: A value other than 0xD0 at the final step of a buffered write returns to read-array mode. The words already written stay in the array.
- R11: The size code 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 select 4 bytes. With BIG_ENDIAN=0 the byte at the address travels in bits 7:0 and higher addresses go to higher lanes. With BIG_ENDIAN=1 the byte at the address travels in the most significant lane of the access. A 1-byte read is zero-extended.
- R12: A first step that is not a known command returns to read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) |
| wrEn | input | 1 | Write strobe, one command step per cycle |
| wrData | input | 32 | Write word; the low byte carries command codes and counts |
| rdEn | input | 1 | Read strobe; rdData is zero when low |
| rdData | output | 32 | Combinational read word chosen by the latched command |

## Verification
The assertions assume three things about the inputs. An access does not rely on wrapping past the top of the array. Write strobes come one per cycle. Reset is held for at least one edge before traffic starts. The stimulus keeps to these rules. It aligns every random address to its access size, holds wrEn for exactly one edge per step, and begins only after reset is released. Random program and erase sequences are mixed with directed cases: aborts, bad confirms, lock codes and query indices past the table.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_QUERY  = 2'd2
  } rdSel_e;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_ARG  = 2'd1,
    CYC_DATA = 2'd2,
    CYC_CONF = 2'd3
  } cyc_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic dataWe;
    logic eraseEn;
    logic statClr;
    logic statReady;
  } dpCtrl_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/flashCtrl.sv
module flashCtrl
  import flashCmdPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] cmdByte,
  output dpCtrl_t    strobe,
  output rdSel_e     rdSel
);

  cyc_e             cyc, nCyc;
  logic [7:0]       cmdReg, nCmd;
  logic [CNT_W-1:0] bufCnt, nCnt;

  always_comb begin
    nCyc   = cyc;
    nCmd   = cmdReg;
    nCnt   = bufCnt;
    strobe = '0;
    if (wrEn) begin
      case (cyc)
        CYC_IDLE: begin
          nCmd = cmdByte;
          case (cmdByte)
            8'h10, 8'h40, 8'h20, 8'h60: nCyc = CYC_ARG;
            8'hE8: begin
              nCyc = CYC_ARG;
              strobe.statReady = 1'b1;
            end
            8'h50: strobe.statClr = 1'b1;
            8'h70, 8'h98: ;
            default: nCmd = 8'h00;
          endcase
        end
        CYC_ARG: begin
          nCyc = CYC_IDLE;
          case (cmdReg)
            8'h10, 8'h40: begin
              strobe.dataWe    = 1'b1;
              strobe.statReady = 1'b1;
            end
            8'h20: begin
              if (cmdByte == 8'hD0) begin
                strobe.eraseEn   = 1'b1;
                strobe.statReady = 1'b1;
              end else begin
                nCmd = 8'h00;
              end
            end
            8'h60: begin
              if (cmdByte != 8'hD0 && cmdByte != 8'h01) nCmd = 8'h00;
            end
            8'hE8: begin
              nCnt = CNT_W'(cmdByte);
              nCyc = CYC_DATA;
            end
            default: nCmd = 8'h00;
          endcase
        end
        CYC_DATA: begin
          strobe.dataWe = 1'b1;
          if (bufCnt == '0) nCyc = CYC_CONF;
          else              nCnt = bufCnt - 1'b1;
        end
        default: begin
          nCyc = CYC_IDLE;
          if (cmdByte == 8'hD0) strobe.statReady = 1'b1;
          else                  nCmd = 8'h00;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyc    <= CYC_IDLE;
      cmdReg <= 8'h00;
      bufCnt <= '0;
    end else begin
      cyc    <= nCyc;
      cmdReg <= nCmd;
      bufCnt <= nCnt;
    end
  end

  always_comb begin
    case (cmdReg)
      8'h20, 8'h50, 8'h60, 8'h70, 8'hE8: rdSel = RD_STATUS;
      8'h98:                             rdSel = RD_QUERY;
      default:                           rdSel = RD_ARRAY;
    endcase
  end

  AST_ABORT_TO_ARRAY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdByte == 8'hFF && (cyc == CYC_IDLE || (cyc == CYC_ARG && cmdReg == 8'h20)))
    |=> (cyc == CYC_IDLE && rdSel == RD_ARRAY)); // R2
  AST_CONFIRM_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cyc == CYC_CONF) |=> (cyc == CYC_IDLE)); // R9
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == CYC_IDLE) |-> (!strobe.dataWe && !strobe.eraseEn)); // R3
  AST_UNKNOWN_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cyc == CYC_IDLE && cmdByte == 8'h33) |=> (rdSel == RD_ARRAY)); // R12

endmodule

// File: rtl/flashData.sv
module flashData
  import flashCmdPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SECTOR_LOG2 = 5,
  parameter bit BIG_ENDIAN  = 1'b0,
  parameter int QLEN        = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  input  dpCtrl_t           strobe,
  input  rdSel_e            rdSel,
  output logic [31:0]       rdData
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int SECT_LEN = 1 << SECTOR_LOG2;
  localparam int NSECT    = DEPTH / SECT_LEN;

  logic [7:0] mem [DEPTH];
  logic [7:0] status;
  logic [2:0] nBytes;
  logic [7:0] inLane [4];
  logic [31:0] arrWord;

  assign nBytes = sizeBytes(size);

  function automatic logic [7:0] qByte(input logic [7:0] i);
    if (int'(i) >= QLEN) return 8'h00;
    case (i)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h15: return 8'h31;
      8'h27: return 8'(ADDR_W);
      8'h2C: return 8'h01;
      8'h2D: return 8'(NSECT - 1);
      8'h2E: return 8'((NSECT - 1) >> 8);
      8'h2F: return 8'(SECT_LEN >> 8);
      8'h30: return 8'(SECT_LEN >> 16);
      8'h31: return 8'h50;
      8'h32: return 8'h52;
      8'h33: return 8'h49;
      8'h34, 8'h35: return 8'h31;
      default: return 8'h00;
    endcase
  endfunction

  // lane k of the access carries the byte at addr+k
  always_comb begin
    arrWord = '0;
    for (int k = 0; k < 4; k++) begin
      int pos;
      pos = BIG_ENDIAN ? (int'(nBytes) - 1 - k) : k;
      if (pos < 0) pos = 0;
      inLane[k] = wrData[8*pos +: 8];
      if (k < int'(nBytes))
        arrWord[8*pos +: 8] = mem[ADDR_W'(addr + ADDR_W'(k))];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (strobe.eraseEn) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [ADDR_W-1:0] iv;
        iv = ADDR_W'(i);
        if (iv[ADDR_W-1:SECTOR_LOG2] == addr[ADDR_W-1:SECTOR_LOG2]) mem[i] <= 8'hFF;
      end
    end else if (strobe.dataWe) begin
      for (int k = 0; k < 4; k++)
        if (k < int'(nBytes)) mem[ADDR_W'(addr + ADDR_W'(k))] <= inLane[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 status    <= 8'h80;
    else if (strobe.statClr)   status    <= 8'h00;
    else if (strobe.statReady) status[7] <= 1'b1;
  end

  always_comb begin
    if (!rdEn) rdData = '0;
    else begin
      case (rdSel)
        RD_STATUS: rdData = {24'h0, status};
        RD_QUERY:  rdData = {24'h0, qByte(8'(addr))};
        default:   rdData = arrWord;
      endcase
    end
  end

  AST_ERASE_READY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseEn |=> status[7]); // R4
  AST_ERASE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseEn |=> (mem[$past(addr)] == 8'hFF)); // R5
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.statClr |=> (status == 8'h00)); // R6
  AST_BYTE_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataWe && size == 2'd0) |=> (mem[$past(addr)] == $past(wrData[7:0]))); // R3

endmodule

// File: rtl/flashCmdTop.sv
module flashCmdTop
  import flashCmdPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SECTOR_LOG2 = 5,
  parameter bit BIG_ENDIAN  = 1'b0,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData
);

  dpCtrl_t strobe;
  rdSel_e  rdSel;

  flashCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .cmdByte (wrData[7:0]),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  flashData #(
    .ADDR_W      (ADDR_W),
    .SECTOR_LOG2 (SECTOR_LOG2),
    .BIG_ENDIAN  (BIG_ENDIAN),
    .QLEN        (64)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .size   (size),
    .wrData (wrData),
    .rdEn   (rdEn),
    .strobe (strobe),
    .rdSel  (rdSel),
    .rdData (rdData)
  );

endmodule

// File: tb/flashCmdTop_test.sv
module flashCmdTop_test;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    size = '0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic          rdEn = 1'b0;
  logic [31:0]   rdData;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;
  logic [7:0] mdl [256];

  flashCmdTop #(.ADDR_W(AW), .SECTOR_LOG2(5), .BIG_ENDIAN(1'b0), .CNT_W(8)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .size(size), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );

  always #5 clk = ~clk;

  function automatic int nOf(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mRead(input int a, input int sz);
    logic [31:0] w = '0;
    for (int k = 0; k < nOf(sz); k++) w[8*k +: 8] = mdl[(a + k) & 255];
    return w;
  endfunction

  task automatic mWrite(input int a, input logic [31:0] d, input int sz);
    for (int k = 0; k < nOf(sz); k++) mdl[(a + k) & 255] = d[8*k +: 8];
  endtask

  task automatic mErase(input int a);
    for (int i = 0; i < 32; i++) mdl[(a & 8'hE0) + i] = 8'hFF;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input int sz);
    @(negedge clk);
    addr = AW'(a); wrData = d; size = 2'(sz); wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, input int sz, output logic [31:0] v);
    @(negedge clk);
    addr = AW'(a); size = 2'(sz); rdEn = 1'b1;
    #1 v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog: got hang expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    rd(8'h00, 2, v); chk("R1 erased array", v, 32'hFFFF_FFFF);
    wr(0, 32'h70, 0); rd(0, 0, v); chk("R1 status after reset", v, 32'h80);
    rd(0, 2, v); chk("R6 status zero-extended at size 4", v, 32'h80);

    // program, lane order
    wr(8'h10, 32'h40, 0); wr(8'h10, 32'h1122_3344, 2); mWrite(8'h10, 32'h1122_3344, 2);
    rd(8'h10, 2, v); chk("R3 program word", v, 32'h1122_3344);
    rd(8'h11, 0, v); chk("R11 byte lane", v, 32'h33);
    rd(8'h12, 1, v); chk("R11 half lane", v, 32'h1122);
    wr(8'h20, 32'h10, 0); wr(8'h20, 32'hFFFF_FFA5, 0); mWrite(8'h20, 32'hA5, 0);
    rd(8'h20, 0, v); chk("R3 program via 0x10", v, 32'hA5);
    rd(8'h20, 3, v); chk("R11 size code 3", v, mRead(8'h20, 3));

    // status clear then ready
    wr(0, 32'h50, 0); rd(0, 0, v); chk("R6 clear", v, 32'h00);
    wr(8'h30, 32'h40, 0); wr(8'h30, 32'h5A, 0); mWrite(8'h30, 32'h5A, 0);
    wr(0, 32'h70, 0); rd(0, 0, v); chk("R3 ready bit", v, 32'h80);

    // erase
    wr(0, 32'h50, 0);
    wr(8'h13, 32'h20, 0); wr(8'h13, 32'hD0, 0); mErase(8'h13);
    rd(8'h13, 0, v); chk("R4 erase status", v, 32'h80);
    wr(0, 32'hFF, 0);
    rd(8'h10, 2, v); chk("R5 sector filled", v, 32'hFFFF_FFFF);
    rd(8'h00, 2, v); chk("R5 sector base", v, 32'hFFFF_FFFF);
    rd(8'h20, 0, v); chk("R5 next sector kept", v, 32'hA5);
    wr(8'h20, 32'h20, 0); wr(8'h20, 32'hFF, 0);
    rd(8'h20, 0, v); chk("R4 abort keeps data", v, 32'hA5);
    chk("R2 abort in array mode", v, 32'hA5);

    // lock
    wr(8'h20, 32'h60, 0); wr(8'h20, 32'h01, 0);
    rd(8'h20, 0, v); chk("R7 lock status", v, 32'h80);
    wr(0, 32'hFF, 0); rd(8'h20, 0, v); chk("R7 lock left array", v, 32'hA5);
    wr(8'h20, 32'h60, 0); wr(8'h20, 32'h33, 0);
    rd(8'h20, 0, v); chk("R7 bad lock code", v, 32'hA5);

    // query
    wr(0, 32'h98, 0);
    rd(8'h10, 0, v); chk("R8 Q", v, 32'h51);
    rd(8'h11, 1, v); chk("R8 R", v, 32'h52);
    rd(8'h12, 2, v); chk("R8 Y", v, 32'h59);
    rd(8'h27, 0, v); chk("R8 size index", v, 32'(AW));
    rd(8'h50, 0, v); chk("R8 past table", v, 32'h00);
    wr(0, 32'hFF, 0); rd(8'h20, 0, v); chk("R2 leave query", v, 32'hA5);

    // buffered write
    wr(0, 32'h50, 0);
    wr(8'h40, 32'hE8, 0); rd(8'h40, 0, v); chk("R9 start ready", v, 32'h80);
    wr(8'h40, 32'h02, 0);
    for (int i = 0; i < 3; i++) begin
      wr(8'h40 + 2*i, 32'hBEE0 + i, 1); mWrite(8'h40 + 2*i, 32'hBEE0 + i, 1);
    end
    wr(8'h40, 32'hD0, 0); rd(8'h40, 0, v); chk("R9 confirm status", v, 32'h80);
    wr(0, 32'hFF, 0);
    for (int i = 0; i < 3; i++) begin
      rd(8'h40 + 2*i, 1, v); chk("R9 buffer word", v, mRead(8'h40 + 2*i, 1));
    end
    rd(8'h46, 1, v); chk("R9 count bound", v, 32'hFFFF);
    wr(8'h60, 32'hE8, 0); wr(8'h60, 32'h00, 0);
    wr(8'h60, 32'hCAFE_F00D, 2); mWrite(8'h60, 32'hCAFE_F00D, 2);
    wr(8'h60, 32'h77, 0);
    rd(8'h60, 2, v); chk("R10 bad confirm", v, 32'hCAFE_F00D);

    // unknown command
    wr(0, 32'h70, 0); wr(0, 32'h33, 0);
    rd(8'h20, 0, v); chk("R12 unknown", v, 32'hA5);

    // random program / erase
    for (int it = 0; it < 200; it++) begin
      int sz, a, op;
      logic [31:0] d;
      sz = int'($urandom % 3);
      a  = int'($urandom % 256) & ~(nOf(sz) - 1);
      d  = $urandom;
      op = int'($urandom % 10);
      if (op == 0) begin
        wr(a, 32'h20, 0); wr(a, 32'hD0, 0); mErase(a); wr(0, 32'hFF, 0);
      end else begin
        wr(a, (op < 5) ? 32'h10 : 32'h40, 0); wr(a, d, sz); mWrite(a, d, sz);
      end
      sz = int'($urandom % 3);
      a  = int'($urandom % 256) & ~(nOf(sz) - 1);
      rd(a, sz, v); chk("R3 R11 random readback", v, mRead(a, sz));
    end

    finishRun();
  end

endmodule